// File: doc/BRIEF.md
# Page Burst Address Sequencer

This block produces the word addresses of one burst read from a memory whose array is divided into 32-byte pages, each made of two 16-byte half-pages. One address step is one 16-bit word, so a page holds sixteen words. A start pulse loads a word address and a burst kind. After that, each advance pulse, one for every word the data path delivers, moves the address on by one step. A stop pulse ends the burst.

In wrapped bursts the address cycles inside an aligned group of 8, 16, 32 or 64 words (16 to 128 bytes). The group base is the start address with its low bits cleared. In linear bursts the address counts up without limit. A one-cycle prefetch request asks for the following page as soon as the first word of a page is presented, so that the next page is read from the array while the current one is still being sent. A separate one-cycle flag marks every move into a different page, in either kind of burst.

Top module: `page_burst_seq`

## Requirements
- R1: After reset, busy_o is 0, addr_o is 0, and both page_cross_o and prefetch_o are 0.
- R2: A start_i pulse without stop_i loads start_addr_i into addr_o and sets busy_o on the next cycle. This also applies while a burst is running: the new burst replaces the old one.
- R3: With linear_i = 0 at start, wrap_sel_i selects a group of 8, 16, 32 or 64 words for codes 0, 1, 2 and 3. Each advance increments the address inside that aligned group, and the step after the group's last word goes back to the group base.
- R4: With linear_i = 1 at start, each advance adds one to addr_o. The address rolls over from the all-ones value to 0.
- R5: page_cross_o is high for exactly the cycle in which an advance has moved addr_o into a different 16-word page (addr_o[ADDR_W-1:4] changed). This holds in both modes. A start never raises it.
- R6: In a linear burst, prefetch_o is high for one cycle on the first cycle of the start page and on the first cycle of each new page. In a wrapped burst it stays low.
- R7: prefetch_page_o always equals the page index of addr_o plus one.
- R8: stop_i forces prefetch_o low in the same cycle and makes busy_o 0 on the next cycle. Stop takes precedence over a start or an advance given in the same cycle, which then have no effect.
- R9: While busy_o is 0, advance pulses leave addr_o unchanged.
- R10: While a burst runs, a cycle without advance, start or stop leaves addr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst at start_addr_i |
| start_addr_i | input | ADDR_W | Start word address |
| linear_i | input | 1 | Burst kind at start: 1 linear, 0 wrapped |
| wrap_sel_i | input | SEL_W | Wrap group code, 0..3 for 8/16/32/64 words |
| adv_i | input | 1 | One word delivered, step the address |
| stop_i | input | 1 | End the burst at once |
| busy_o | output | 1 | A burst is running |
| addr_o | output | ADDR_W | Current word address |
| page_cross_o | output | 1 | Address has just entered a new page |
| prefetch_o | output | 1 | Request to fetch the next page |
| prefetch_page_o | output | ADDR_W-4 | Page index to prefetch |

## Verification
Several situations are hard to reach from the ports. One is a wrapped group that spans more than one page, where a wrap back to the group base must still be reported as a page change. Another is the roll-over of a linear burst at the top of the address space. The most delicate is a stop that arrives in the very cycle a prefetch request is showing. The bench drives all three directly. Vectors start a 32-word and a 64-word wrap just before the end of their group, and start a linear burst two words below the top address. A directed sequence raises stop in the cycle a restart has set prefetch_o high and samples prefetch_o after stop settles, before the next edge.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pbs_wrap_masks.sv
module pbs_wrap_masks #(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned NUM_WRAP = 4,
   parameter int unsigned MIN_LOG  = 3,
   parameter int unsigned SEL_W    = 2
) (
   input  logic [SEL_W-1:0]  sel_i,
   output logic [ADDR_W-1:0] mask_o
);

   logic [ADDR_W-1:0] tbl [NUM_WRAP];

   for (genvar k = 0; k < NUM_WRAP; k++) begin : g_mask
      localparam int unsigned GROUP_LOG = MIN_LOG + k;
      for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
         assign tbl[k][b] = (b < GROUP_LOG) ? 1'b1 : 1'b0;
      end
   end

   always_comb begin
      mask_o = tbl[0];
      for (int k = 0; k < NUM_WRAP; k++) begin
         if (sel_i == SEL_W'(k)) mask_o = tbl[k];
      end
   end

endmodule

// File: rtl/pbs_next_addr.sv
module pbs_next_addr #(
   parameter int unsigned ADDR_W = 24
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] mask_i,
   input  logic              linear_i,
   output logic [ADDR_W-1:0] next_o
);

   logic [ADDR_W-1:0] inc;

   assign inc = addr_i + {{(ADDR_W-1){1'b0}}, 1'b1};

   // bits inside the group (or every bit when linear) take the incremented
   // value; bits above the group keep the current one
   for (genvar b = 0; b < ADDR_W; b++) begin : g_merge
      assign next_o[b] = (linear_i | mask_i[b]) ? inc[b] : addr_i[b];
   end

endmodule

// File: rtl/pbs_page_watch.sv
module pbs_page_watch #(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned PAGE_WBITS = 4,
   localparam int unsigned PIDX_W    = ADDR_W - PAGE_WBITS
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [ADDR_W-1:0] nxt_i,
   output logic              cross_o,
   output logic [PIDX_W-1:0] next_page_o
);

   logic [PIDX_W-1:0] cur_page;
   logic [PIDX_W-1:0] nxt_page;

   assign cur_page    = cur_i[ADDR_W-1:PAGE_WBITS];
   assign nxt_page    = nxt_i[ADDR_W-1:PAGE_WBITS];
   assign cross_o     = (cur_page != nxt_page);
   assign next_page_o = cur_page + {{(PIDX_W-1){1'b0}}, 1'b1};

endmodule

// File: rtl/page_burst_seq.sv
module page_burst_seq #(
   parameter int unsigned ADDR_W         = 24,
   parameter int unsigned WORD_BYTES     = 2,
   parameter int unsigned HALF_BYTES     = 16,
   parameter int unsigned PAGE_BYTES     = 32,
   parameter int unsigned MIN_WRAP_BYTES = 16,
   parameter int unsigned NUM_WRAP       = 4,
   localparam int unsigned SEL_W         = $clog2(NUM_WRAP),
   localparam int unsigned PAGE_WBITS    = $clog2(PAGE_BYTES / WORD_BYTES),
   localparam int unsigned PIDX_W        = ADDR_W - PAGE_WBITS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              linear_i,
   input  logic [SEL_W-1:0]  wrap_sel_i,
   input  logic              adv_i,
   input  logic              stop_i,
   output logic              busy_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              page_cross_o,
   output logic              prefetch_o,
   output logic [PIDX_W-1:0] prefetch_page_o
);

   import pbs_pkg::*;

   localparam int unsigned MIN_LOG = $clog2(MIN_WRAP_BYTES / WORD_BYTES);

   // elaboration-time parameter checks
   if (!is_pow2(WORD_BYTES) || !is_pow2(HALF_BYTES) || !is_pow2(PAGE_BYTES)) begin : g_bad_pow2
      $error("page_burst_seq: byte sizes must be powers of two");
   end
   if (PAGE_BYTES != 2 * HALF_BYTES) begin : g_bad_half
      $error("page_burst_seq: a page must hold exactly two half-pages");
   end
   if (!is_pow2(MIN_WRAP_BYTES) || MIN_WRAP_BYTES < WORD_BYTES) begin : g_bad_wrap
      $error("page_burst_seq: minimum wrap size must be a power of two of at least one word");
   end
   if (NUM_WRAP < 2 || !is_pow2(NUM_WRAP)) begin : g_bad_nwrap
      $error("page_burst_seq: NUM_WRAP must be a power of two, at least 2");
   end
   if (MIN_LOG + NUM_WRAP - 1 >= ADDR_W || PAGE_WBITS >= ADDR_W) begin : g_bad_addr
      $error("page_burst_seq: address too narrow for page or wrap group");
   end

   seq_state_e        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] mask_q;
   logic              lin_q;
   logic              pc_q;
   logic              pf_q;

   logic [ADDR_W-1:0] sel_mask;
   logic [ADDR_W-1:0] nxt_addr;
   logic              nxt_cross;

   pbs_wrap_masks #(
      .ADDR_W   (ADDR_W),
      .NUM_WRAP (NUM_WRAP),
      .MIN_LOG  (MIN_LOG),
      .SEL_W    (SEL_W)
   ) u_masks (
      .sel_i  (wrap_sel_i),
      .mask_o (sel_mask)
   );

   pbs_next_addr #(
      .ADDR_W (ADDR_W)
   ) u_next (
      .addr_i   (addr_q),
      .mask_i   (mask_q),
      .linear_i (lin_q),
      .next_o   (nxt_addr)
   );

   pbs_page_watch #(
      .ADDR_W     (ADDR_W),
      .PAGE_WBITS (PAGE_WBITS)
   ) u_watch (
      .cur_i       (addr_q),
      .nxt_i       (nxt_addr),
      .cross_o     (nxt_cross),
      .next_page_o (prefetch_page_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         mask_q <= '0;
         lin_q  <= 1'b0;
         pc_q   <= 1'b0;
         pf_q   <= 1'b0;
      end else begin
         pc_q <= 1'b0;
         pf_q <= 1'b0;
         if (stop_i) begin
            st_q <= ST_IDLE;
         end else if (start_i) begin
            st_q   <= ST_RUN;
            addr_q <= start_addr_i;
            mask_q <= sel_mask;
            lin_q  <= linear_i;
            pf_q   <= linear_i;
         end else if (st_q == ST_RUN && adv_i) begin
            addr_q <= nxt_addr;
            pc_q   <= nxt_cross;
            pf_q   <= lin_q & nxt_cross;
         end
      end
   end

   assign busy_o       = (st_q == ST_RUN);
   assign addr_o       = addr_q;
   assign page_cross_o = pc_q;
   assign prefetch_o   = pf_q & ~stop_i;

endmodule

// File: rtl/page_burst_seq_chk.sv
module page_burst_seq_chk #(
   parameter int unsigned ADDR_W = 24
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic              adv_i,
   input logic              stop_i,
   input logic              busy_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              page_cross_o,
   input logic              prefetch_o,
   input logic              lin_q,
   input logic [ADDR_W-1:0] mask_q
);

   p_wrap_group_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && adv_i && !start_i && !stop_i && !lin_q) |=>
      ((addr_o & ~$past(mask_q)) == ($past(addr_o) & ~$past(mask_q))));

   p_linear_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && adv_i && !start_i && !stop_i && lin_q) |=>
      (addr_o == $past(addr_o) + {{(ADDR_W-1){1'b0}}, 1'b1}));

   p_cross_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      page_cross_o |=> !page_cross_o);

   p_no_cross_on_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !stop_i) |=> !page_cross_o);

   p_pf_linear_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prefetch_o |-> (lin_q && busy_o));

   p_stop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> (!busy_o && !page_cross_o));

   p_stop_no_pf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |-> !prefetch_o);

   p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !start_i) |=> $stable(addr_o));

   p_run_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !adv_i && !start_i && !stop_i) |=> $stable(addr_o));

endmodule

bind page_burst_seq page_burst_seq_chk #(
   .ADDR_W (ADDR_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .start_i      (start_i),
   .adv_i        (adv_i),
   .stop_i       (stop_i),
   .busy_o       (busy_o),
   .addr_o       (addr_o),
   .page_cross_o (page_cross_o),
   .prefetch_o   (prefetch_o),
   .lin_q        (lin_q),
   .mask_q       (mask_q)
);

// File: tb/test_page_burst_seq.sv
module test_page_burst_seq;

   localparam int AW = 24;
   localparam int PW = AW - 4;

   typedef struct packed {
      logic [AW-1:0] sa;
      logic          lin;
      logic [1:0]    sel;
      logic [7:0]    n;
      logic [AW-1:0] fin;
      logic [3:0]    pcs;
      logic [3:0]    pfs;
   } vec_t;

   // start, linear, wrap code, advances, final address, page crossings, prefetches
   localparam vec_t VEC [0:7] = '{
      '{24'h000005, 1'b0, 2'd0, 8'd5,  24'h000002, 4'd0, 4'd0},  // R3 8-word wrap
      '{24'h00001E, 1'b0, 2'd1, 8'd3,  24'h000011, 4'd0, 4'd0},  // R3 16-word wrap
      '{24'h00003C, 1'b0, 2'd2, 8'd6,  24'h000022, 4'd1, 4'd0},  // R3 R5 32-word wrap across page
      '{24'h00007F, 1'b0, 2'd3, 8'd2,  24'h000041, 4'd1, 4'd0},  // R3 R5 64-word wrap
      '{24'h00000E, 1'b1, 2'd0, 8'd20, 24'h000022, 4'd2, 4'd3},  // R4 R6 linear two crossings
      '{24'hFFFFFE, 1'b1, 2'd3, 8'd3,  24'h000001, 4'd1, 4'd2},  // R4 roll-over
      '{24'h000010, 1'b1, 2'd1, 8'd0,  24'h000010, 4'd0, 4'd1},  // R6 start only
      '{24'h000123, 1'b1, 2'd2, 8'd16, 24'h000133, 4'd1, 4'd2}   // R4 R5 R6
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          linear = 1'b0;
   logic [1:0]    wrap_sel = '0;
   logic          adv = 1'b0;
   logic          stop = 1'b0;
   logic          busy;
   logic [AW-1:0] addr;
   logic          pcross;
   logic          pf;
   logic [PW-1:0] pf_page;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   page_burst_seq i_page_burst_seq (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .start_i         (start),
      .start_addr_i    (start_addr),
      .linear_i        (linear),
      .wrap_sel_i      (wrap_sel),
      .adv_i           (adv),
      .stop_i          (stop),
      .busy_o          (busy),
      .addr_o          (addr),
      .page_cross_o    (pcross),
      .prefetch_o      (pf),
      .prefetch_page_o (pf_page)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic begin_burst(input logic [AW-1:0] a, input logic lin, input logic [1:0] sel);
      @(negedge clk);
      start      = 1'b1;
      start_addr = a;
      linear     = lin;
      wrap_sel   = sel;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      int pcs = 0;
      int pfs = 0;
      begin_burst(v.sa, v.lin, v.sel);
      for (int k = 0; k <= int'(v.n); k++) begin
         if (k > 0) @(negedge clk);
         if (pcross) pcs++;
         if (pf) begin
            pfs++;
            check(pf_page == addr[AW-1:4] + 1'b1, "R7 prefetch page", 32'(pf_page), 32'(addr[AW-1:4] + 1'b1));
         end
         adv = (k < int'(v.n));
      end
      adv = 1'b0;
      check(addr == v.fin, v.lin ? "R4 final address" : "R3 final address", 32'(addr), 32'(v.fin));
      check(pcs == int'(v.pcs), "R5 page crossings", 32'(pcs), 32'(v.pcs));
      check(pfs == int'(v.pfs), "R6 prefetch count", 32'(pfs), 32'(v.pfs));
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check(busy == 1'b0, "R8 idle after stop", 32'(busy), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 1'b0 && pcross == 1'b0 && pf == 1'b0, "R1 flags in reset", {busy, pcross, pf}, 32'd0);
      check(addr == '0, "R1 address in reset", 32'(addr), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && addr == '0, "R1 after reset release", 32'(addr), 32'd0);

      for (int i = 0; i < 8; i++) run_vec(VEC[i]);

      // R9 advance while idle
      adv = 1'b1;
      repeat (3) @(negedge clk);
      adv = 1'b0;
      check(addr == 24'h000133, "R9 idle advance ignored", 32'(addr), 32'h133);
      check(busy == 1'b0, "R9 still idle", 32'(busy), 32'd0);

      // R10 hold without advance, R6 no prefetch in wrap mode
      begin_burst(24'h000040, 1'b0, 2'd0);
      check(addr == 24'h000040 && busy, "R2 wrap start loaded", 32'(addr), 32'h40);
      check(pf == 1'b0, "R6 no prefetch when wrapped", 32'(pf), 32'd0);
      repeat (3) @(negedge clk);
      check(addr == 24'h000040, "R10 hold", 32'(addr), 32'h40);

      // R2 restart while busy
      adv = 1'b1;
      repeat (2) @(negedge clk);
      adv = 1'b0;
      check(addr == 24'h000042, "R3 two steps", 32'(addr), 32'h42);
      start      = 1'b1;
      start_addr = 24'h000500;
      linear     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(addr == 24'h000500 && busy, "R2 restart", 32'(addr), 32'h500);
      check(pf == 1'b1, "R6 prefetch at restart", 32'(pf), 32'd1);
      check(pcross == 1'b0, "R5 no cross on start", 32'(pcross), 32'd0);
      check(pf_page == 20'h00051, "R7 restart page", 32'(pf_page), 32'h51);

      // R8 stop masks a showing prefetch
      stop = 1'b1;
      #1;
      check(pf == 1'b0, "R8 prefetch suppressed", 32'(pf), 32'd0);
      @(negedge clk);
      stop = 1'b0;
      check(busy == 1'b0, "R8 idle", 32'(busy), 32'd0);

      // R8 stop beats start
      @(negedge clk);
      start      = 1'b1;
      stop       = 1'b1;
      start_addr = 24'h000777;
      @(negedge clk);
      start = 1'b0;
      stop  = 1'b0;
      check(busy == 1'b0 && addr == 24'h000500, "R8 stop over start", 32'(addr), 32'h500);

      // R8 stop beats advance
      begin_burst(24'h00002F, 1'b1, 2'd0);
      adv  = 1'b1;
      stop = 1'b1;
      @(negedge clk);
      adv  = 1'b0;
      stop = 1'b0;
      check(addr == 24'h00002F && busy == 1'b0, "R8 stop over advance", 32'(addr), 32'h2F);
      check(pcross == 1'b0, "R8 no cross after stop", 32'(pcross), 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule